// File: doc/BRIEF.md
# Selectable Clock-Enable Source with Fractional Rate Divider

This block picks one of ten clock-enable pulse streams, all in the same system clock domain, and thins the chosen stream by a programmable ratio that has an integer part and a fraction part. The result is a single enable stream, `tick_out`. Over many pulses its average rate is the chosen source rate times 2^FRAC_BITS, divided by the programmed divisor. A phase accumulator produces the ratio. Each selected source pulse adds 2^FRAC_BITS to the accumulator. Whenever the sum reaches the divisor, the block subtracts the divisor and emits one output pulse.

Software sets up the block through two 32-bit registers that share one write/read port. Address 0 holds the control word: source select, enable, and a busy flag. Address 1 holds the divider word. Each instance fixes its integer and fraction widths at elaboration. When both widths are zero, the divider logic is left out and the selected source passes through one register stage.

Top module: `clkmux_fracdiv`

## Requirements
- R1: Control bits 3:0 choose the source. A code from 0 to 9 selects `src_en[code]`. Pulses on any source that is not selected never produce an output pulse.
- R2: Select codes 10 to 15 read back as written but act as a silent source, so no output pulses appear.
- R3: Control bit 4 is the enable. While it is 0, `tick_out` stays low and the accumulator is held at zero.
- R4: Control bit 5 is busy. It always reads equal to bit 4, and any value written to it is ignored. All other control bits read back as written.
- R5: The divisor is {integer, fraction}. The integer part is the low INT_BITS of divider bits from 12 upward. The fraction part is divider bits 11 down to 12-FRAC_BITS. Lower fraction bits and bits above the integer field do not affect the rate, and the whole divider word reads back as written.
- R6: For a divisor D of at least 2^FRAC_BITS, N selected pulses after a clear give floor(N·2^FRAC_BITS/D) output pulses. Each output pulse is high for exactly the one cycle that follows the source pulse that caused it.
- R7: For a divisor from 1 to 2^FRAC_BITS-1, every selected source pulse gives one output pulse.
- R8: A divisor of zero stops the output completely.
- R9: With INT_BITS = FRAC_BITS = 0, `tick_out` equals the selected source pulse of the previous cycle, gated by enable.
- R10: A write to either register clears the accumulator. A source pulse in the cycle of the write produces no output pulse, and a new selection takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | NUM_SRC | Clock-enable pulses from each source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 divider |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tick_out | output | 1 | Divided clock-enable pulse output |

## Verification
The assertions check several rules on every cycle: the output is silent while disabled or while the divisor is zero, every output pulse traces back to a pulse on the selected source, writes clear the accumulator, the accumulator stays below the divisor, the busy flag mirrors enable, and the bypass path is exact. Only the bench's scenarios can show the average rate. It sweeps every divisor value and compares pulse counts with the closed-form floor result. The bench scenarios also show that select codes 10 to 15 stay silent, and that clearing the accumulator on a write changes when the next pulse arrives.

// File: rtl/clkmux_fracdiv.sv
module clkmux_fracdiv #(
  parameter int NUM_SRC   = 10,
  parameter int SEL_W     = 4,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               tick_out
);
  localparam int PADW = 1 << SEL_W;
  localparam int DW   = INT_BITS + FRAC_BITS;
  localparam int AW   = DW + 1;

  logic [4:0]      ctrl_lo;
  logic [31:6]     ctrl_hi;
  logic [31:0]     div_q;
  logic [PADW-1:0] src_pad;
  logic            enable, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_lo <= '0;
      ctrl_hi <= '0;
      div_q   <= '0;
    end else if (reg_wr) begin
      if (!reg_addr) begin
        ctrl_lo <= reg_wdata[4:0];
        ctrl_hi <= reg_wdata[31:6];
      end else begin
        div_q <= reg_wdata;
      end
    end
  end

  assign enable    = ctrl_lo[4];
  assign src_pad   = PADW'(src_en);
  assign hit       = src_pad[ctrl_lo[SEL_W-1:0]];
  assign reg_rdata = reg_addr ? div_q : {ctrl_hi, enable, ctrl_lo};

  generate
    if (DW == 0) begin : g_bypass
      always_ff @(posedge clk) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= enable && hit && !reg_wr;
      end

      a_r9_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out == $past(enable && hit && !reg_wr));
    end else begin : g_divide
      logic [DW-1:0] divisor;
      logic [AW-1:0] acc, inc, sum, div_x;

      always_comb begin
        for (int i = 0; i < DW; i++) divisor[i] = div_q[12 - FRAC_BITS + i];
      end

      assign inc   = AW'(1) << FRAC_BITS;
      assign sum   = acc + inc;
      assign div_x = {1'b0, divisor};

      always_ff @(posedge clk) begin
        if (!rst_n || reg_wr) begin
          acc      <= '0;
          tick_out <= 1'b0;
        end else begin
          tick_out <= 1'b0;
          if (!enable || divisor == '0) begin
            acc <= '0;
          end else if (hit) begin
            if (div_x < inc) begin
              acc      <= '0;
              tick_out <= 1'b1;
            end else if (sum >= div_x) begin
              acc      <= sum - div_x;
              tick_out <= 1'b1;
            end else begin
              acc <= sum;
            end
          end
        end
      end

      a_r8_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(divisor == '0) |-> !tick_out);
      a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr) |-> (acc == '0 && !tick_out));
      a_r6_acc_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        acc == '0 || acc < div_x);
      a_r3_acc_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> acc == '0);
    end
  endgenerate

  a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !tick_out);
  a_r1_from_selected: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(hit));
  a_r4_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> reg_rdata[5] == reg_rdata[4]);
endmodule

// File: tb/tb_clkmux_fracdiv.sv
module tb_clkmux_fracdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  src_en = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_d, rd_b;
  logic        tick_d, tick_b;
  int checks = 0, failures = 0, cnt_d = 0, cnt_b = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkmux_fracdiv #(.INT_BITS(4), .FRAC_BITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_d), .tick_out(tick_d));

  clkmux_fracdiv #(.INT_BITS(0), .FRAC_BITS(0)) dut_bp (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_b), .tick_out(tick_b));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] s, input logic w, input logic a, input logic [31:0] d);
    @(negedge clk);
    cnt_d += int'(tick_d);
    cnt_b += int'(tick_b);
    src_en = s; reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wreg(input logic a, input logic [31:0] d);
    step('0, 1'b1, a, d);
    step('0, 1'b0, a, '0);
  endtask

  task automatic run(input int n, input int src);
    cnt_d = 0; cnt_b = 0;
    for (int i = 0; i < n; i++) step(10'(1) << src, 1'b0, reg_addr, '0);
    for (int i = 0; i < 3; i++) step('0, 1'b0, reg_addr, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 1'b0; #1;
    chk("R4 reset ctrl", rd_d, 0);
    reg_addr = 1'b1; #1;
    chk("R5 reset div", rd_d, 0);
    run(5, 0);
    chk("R3 reset silent", cnt_d + cnt_b, 0);

    wreg(1'b0, 32'hABCD_12DF);
    reg_addr = 1'b0; #1;
    chk("R4 busy reads enable", rd_d, 32'hABCD_12FF);
    wreg(1'b1, 32'h0000_1000);
    for (int k = 0; k < 10; k++) begin
      run(6, k);
      chk("R2 code 15 silent", cnt_d, 0);
      chk("R2 code 15 silent bypass", cnt_b, 0);
    end
    wreg(1'b0, 32'hABCD_12EF);
    reg_addr = 1'b0; #1;
    chk("R4 busy write ignored", rd_d, 32'hABCD_12CF);

    for (int s = 0; s < 16; s++) begin
      wreg(1'b0, 32'h10 | 32'(s));
      for (int k = 0; k < 10; k++) begin
        run(6, k);
        chk((s < 10) ? "R1 select" : "R2 out of range", cnt_d, (k == s && s < 10) ? 6 : 0);
        chk("R9 bypass select", cnt_b, (k == s && s < 10) ? 6 : 0);
      end
    end

    wreg(1'b0, 32'h12);
    wreg(1'b0, 32'h02);
    run(20, 2);
    chk("R3 disabled", cnt_d, 0);
    chk("R9 bypass disabled", cnt_b, 0);
    wreg(1'b0, 32'h12);

    for (int d = 0; d < 256; d++) begin
      logic [31:0] dw;
      dw = 32'hF000_00A5 | (32'(d) << 8);
      wreg(1'b1, dw);
      reg_addr = 1'b1; #1;
      if (d % 51 == 0) chk("R5 divider readback", rd_d, dw);
      run(40, 2);
      if (d == 0)       chk("R8 zero divisor", cnt_d, 0);
      else if (d < 16)  chk("R7 fast ratio", cnt_d, 40);
      else              chk("R6 average rate", cnt_d, (40 * 16) / d);
      chk("R9 bypass ignores divider", cnt_b, 40);
    end

    wreg(1'b1, 32'h0000_1000);
    step(10'b100, 1'b0, 1'b1, '0);
    step('0, 1'b0, 1'b1, '0);
    chk("R6 tick next cycle", tick_d, 1);
    chk("R9 bypass next cycle", tick_b, 1);
    step('0, 1'b0, 1'b1, '0);
    chk("R6 tick one cycle", tick_d, 0);

    step(10'b100, 1'b1, 1'b1, 32'h0000_1000);
    step('0, 1'b0, 1'b1, '0);
    chk("R10 pulse in write cycle", tick_d, 0);

    wreg(1'b1, 32'h0000_3000);
    run(2, 2);
    chk("R10 partial phase", cnt_d, 0);
    wreg(1'b1, 32'h0000_3000);
    run(2, 2);
    chk("R10 accumulator cleared", cnt_d, 0);
    run(1, 2);
    chk("R10 pulse after refill", cnt_d, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule